// File: doc/BRIEF.md
# Synchronous Burst PSRAM Controller

This block runs burst reads and writes against a synchronous pseudo-static RAM on a single chip select. It divides the controller clock down to a memory clock and waits a programmed number of memory cycles of latency before the first data word. It honours a wait input from the device, and data words stream through a simple per-beat strobe interface. A request carries a byte start address, a word count and a direction. Once accepted, the block runs the whole burst alone and raises `done` after the final word.

Long bursts are cut into pieces so that the device can refresh. A piece ends where the next address would cross a programmable page boundary, or when chip select has been low for a programmable number of memory cycles. Between pieces chip select goes high for one memory clock period. The next piece then starts at the following address and runs the full latency again. `mem_addr` always shows the address of the next word. The device latches it when chip select falls.

Configuration inputs are quasi-static. They may change only while `busy` is low.

Top module: `psram_burst_ctrl`

## Requirements
- R1: After reset `mem_cs_n` is 1 and `mem_clk`, `busy`, `done`, `rd_valid` and `wr_ack` are 0.
- R2: The memory clock period is P = 2*`cfg_half` controller cycles: low for the first half, high for the second. With `cfg_cclk`=0 it toggles only while chip select is low. With `cfg_cclk`=1 it toggles all the time, including while idle.
- R3: In every piece the first word is taken in memory cycle `cfg_lat`+1 after chip select falls. For reads, the first `rd_valid` appears (`cfg_lat`+1)*P controller cycles after chip select falls. `mem_wait` is ignored during the latency cycles.
- R4: A read returns one `rd_valid` pulse per word. `rd_data` is the value that `mem_dq_in` held for address start+2*i, taken in order.
- R5: A write pulses `wr_ack` once per word in the memory cycle where the device takes it. In that cycle `mem_we_n`=0, `mem_dq_oe`=1, `mem_dq_out`=`wr_data` and `mem_addr`=start+2*i.
- R6: With `cfg_wait_early`=0, `mem_wait`=1 at the end of a data memory cycle stalls that cycle. No word moves and `mem_addr` holds.
- R7: With `cfg_wait_early`=1, `mem_wait` sampled in one data memory cycle stalls the next data memory cycle.
- R8: `cfg_page` codes are 1=128, 2=256, 3=512 and 4=1024 bytes. Any other code means no page splitting. A piece ends after the word whose next address is a multiple of the page size, and the next piece starts at that address.
- R9: With `cfg_maxlow`=M>0, chip select stays low for at most M*P controller cycles per piece. Without wait states, each piece carries M-`cfg_lat` words. M=0 disables the limit. M must exceed `cfg_lat`.
- R10: Between pieces of one burst, chip select is high for exactly P controller cycles.
- R11: `done` is a one-cycle pulse on the cycle after the final word's memory cycle, however many pieces the burst used. `busy` is low in that cycle.
- R12: `req_len_m1` gives a word count of `req_len_m1`+1, from 1 to 256. A request made while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | controller clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_half | input | HW | memory clock half period in controller cycles (>=1) |
| cfg_lat | input | TW | latency in memory cycles before the first word (>=1) |
| cfg_page | input | 3 | page size code |
| cfg_maxlow | input | MW | maximum chip-select-low time in memory cycles, 0 = off |
| cfg_wait_early | input | 1 | wait is signalled one data cycle ahead |
| cfg_cclk | input | 1 | run the memory clock continuously |
| req_valid | input | 1 | burst request strobe |
| req_write | input | 1 | 1 = write burst |
| req_addr | input | AW | byte start address |
| req_len_m1 | input | LW | word count minus one |
| busy | output | 1 | a burst is pending or running |
| done | output | 1 | burst finished pulse |
| wr_data | input | DW | current write word |
| wr_ack | output | 1 | write word taken |
| rd_data | output | DW | read word |
| rd_valid | output | 1 | read word strobe |
| mem_clk | output | 1 | memory clock |
| mem_cs_n | output | 1 | chip select, active low |
| mem_we_n | output | 1 | write enable, active low |
| mem_addr | output | AW | address of next word |
| mem_dq_out | output | DW | write data to the device |
| mem_dq_oe | output | 1 | data output enable |
| mem_dq_in | input | DW | read data from the device |
| mem_wait | input | 1 | device wait, active high |

## Verification
The assertions check on every cycle that the memory clock is gated while chip select is high, that every write strobe comes with chip select, write enable and the data driver active, that the address holds through a stalled data cycle, that chip-select-low time stays within the limit, that the high gap between pieces lasts at least one memory period, and that `done` is a lone pulse with `busy` low. Only the bench scenarios can show whether the data words, the split addresses, the exact latency, and which cycle a wait stalls in each wait mode match the requirements. They also show that a request made while busy leaves no trace.

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int LW = 8,
  parameter int HW = 8,
  parameter int TW = 4,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_half,
  input  logic [TW-1:0] cfg_lat,
  input  logic [2:0]    cfg_page,
  input  logic [MW-1:0] cfg_maxlow,
  input  logic          cfg_wait_early,
  input  logic          cfg_cclk,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len_m1,
  output logic          busy,
  output logic          done,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ack,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          mem_clk,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  input  logic          mem_wait
);
  localparam int BYTES = DW / 8;

  typedef enum logic [1:0] {IDLE, LAT, DATA, GAP} st_t;
  st_t st;

  logic [HW:0]   dcnt;
  logic [AW-1:0] addr;
  logic [LW-1:0] rem;
  logic [TW-1:0] latc;
  logic [MW-1:0] lowc;
  logic          wr_q, pend, wait_q;
  logic [10:0]   pmask;

  wire [HW+1:0] per   = {1'b0, cfg_half, 1'b0};
  wire [HW+1:0] dnext = {1'b0, dcnt} + {{(HW+1){1'b0}}, 1'b1};
  wire tick     = dnext >= per;
  wire in_piece = (st == LAT) || (st == DATA);
  wire eff_wait = cfg_wait_early ? wait_q : mem_wait;
  wire beat     = tick && (st == DATA) && !eff_wait;
  wire [AW-1:0] nxt = addr + AW'(BYTES);

  always_comb begin
    case (cfg_page)
      3'd1:    pmask = 11'd127;
      3'd2:    pmask = 11'd255;
      3'd3:    pmask = 11'd511;
      3'd4:    pmask = 11'd1023;
      default: pmask = 11'd0;
    endcase
  end

  wire [MW:0] lowc_n = {1'b0, lowc} + {{MW{1'b0}}, 1'b1};
  wire [TW:0] latc_n = {1'b0, latc} + {{TW{1'b0}}, 1'b1};
  wire page_hit  = (pmask != 11'd0) && ((nxt[10:0] & pmask) == 11'd0);
  wire limit_hit = (cfg_maxlow != '0) && (lowc_n >= {1'b0, cfg_maxlow});

  assign busy       = (st != IDLE) || pend;
  assign mem_cs_n   = !in_piece;
  assign mem_clk    = (cfg_cclk || in_piece) && (dcnt >= {1'b0, cfg_half});
  assign mem_we_n   = !(in_piece && wr_q);
  assign mem_dq_oe  = (st == DATA) && wr_q;
  assign mem_dq_out = wr_data;
  assign mem_addr   = addr;
  assign wr_ack     = beat && wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else        dcnt <= tick ? '0 : dnext[HW:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; addr <= '0; rem <= '0; wr_q <= 1'b0; pend <= 1'b0;
      latc <= '0; lowc <= '0; wait_q <= 1'b0;
      done <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      done     <= beat && (rem == '0);
      rd_valid <= beat && !wr_q;
      if (beat && !wr_q) rd_data <= mem_dq_in;
      if (req_valid && !busy) begin
        addr <= req_addr; rem <= req_len_m1; wr_q <= req_write; pend <= 1'b1;
      end
      case (st)
        IDLE: if (tick && pend) begin
          st <= LAT; pend <= 1'b0; latc <= '0; lowc <= '0; wait_q <= 1'b0;
        end
        LAT: if (tick) begin
          lowc <= lowc_n[MW-1:0];
          latc <= latc_n[TW-1:0];
          if (latc_n >= {1'b0, cfg_lat}) st <= DATA;
        end
        DATA: if (tick) begin
          lowc   <= lowc_n[MW-1:0];
          wait_q <= mem_wait;
          if (beat) begin
            addr <= nxt;
            rem  <= rem - 1'b1;
            if (rem == '0)                st <= IDLE;
            else if (page_hit || limit_hit) st <= GAP;
          end else if (limit_hit) begin
            st <= GAP;
          end
        end
        GAP: if (tick) begin
          st <= LAT; latc <= '0; lowc <= '0; wait_q <= 1'b0;
        end
        default: st <= IDLE;
      endcase
    end
  end

  logic [31:0] lowcyc, hicyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcyc <= '0; hicyc <= 32'hFFFF_FFFF;
    end else begin
      lowcyc <= mem_cs_n ? 32'd0 : lowcyc + 32'd1;
      hicyc  <= !mem_cs_n ? 32'd0 : (hicyc == 32'hFFFF_FFFF ? hicyc : hicyc + 32'd1);
    end
  end

  a_r2_clk_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_cclk && mem_cs_n) |-> !mem_clk);
  a_r5_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> (!mem_cs_n && !mem_we_n && mem_dq_oe));
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == DATA) && tick && eff_wait) |=> $stable(mem_addr));
  a_r9_low_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_maxlow != '0) |-> (lowcyc <= 32'(cfg_maxlow) * 32'(per)));
  a_r10_gap_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> (hicyc >= 32'(per) - 32'd1));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));
endmodule

// File: tb/tb_psram_burst_ctrl.sv
module tb_psram_burst_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] cfg_half = 8'd1;
  logic [3:0] cfg_lat = 4'd2;
  logic [2:0] cfg_page = 3'd0;
  logic [7:0] cfg_maxlow = 8'd0;
  logic cfg_wait_early = 0, cfg_cclk = 0;
  logic req_valid = 0, req_write = 0;
  logic [23:0] req_addr = '0;
  logic [7:0] req_len_m1 = '0;
  logic busy, done, wr_ack, rd_valid, mem_clk, mem_cs_n, mem_we_n, mem_dq_oe;
  logic [15:0] wr_data = '0, rd_data, mem_dq_out, mem_dq_in;
  logic [23:0] mem_addr;
  logic mem_wait = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_dq_in = mem_addr[15:0] ^ 16'h5A3C;

  psram_burst_ctrl dut (.*);

  int n_checks = 0, n_fail = 0, cyc = 0, done_cnt = 0;
  int first_fall = -1, fall_cyc = 0, rise_cyc = 0;
  bit gap_pending = 0, prev_cs = 1;
  int rv_times[$];
  logic [15:0] exp_rd[$], wdata_q[$], exp_wd[$];
  logic [23:0] exp_wa[$], exp_piece[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int per();
    return 2 * int'(cfg_half);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (rd_valid) begin
        rv_times.push_back(cyc);
        if (exp_rd.size() == 0) chk(0, "R4 unexpected read word", rd_data, 0);
        else begin
          logic [15:0] e; e = exp_rd.pop_front();
          chk(rd_data == e, "R4 read data", rd_data, e);
        end
      end
      if (wr_ack) begin
        if (exp_wa.size() == 0) chk(0, "R5 unexpected write word", mem_addr, 0);
        else begin
          logic [23:0] ea; logic [15:0] ed;
          ea = exp_wa.pop_front(); ed = exp_wd.pop_front();
          chk(mem_addr == ea, "R5 write address", mem_addr, ea);
          chk(mem_dq_out == ed, "R5 write data", mem_dq_out, ed);
        end
        if (wdata_q.size() != 0) void'(wdata_q.pop_front());
      end
      wr_data = (wdata_q.size() != 0) ? wdata_q[0] : 16'h0;
      if (prev_cs && !mem_cs_n) begin
        fall_cyc = cyc;
        if (first_fall < 0) first_fall = cyc;
        if (exp_piece.size() == 0) chk(0, "R8 unexpected piece", mem_addr, 0);
        else begin
          logic [23:0] ep; ep = exp_piece.pop_front();
          chk(mem_addr == ep, "R8 R9 piece start address", mem_addr, ep);
        end
        if (gap_pending) chk(cyc - rise_cyc == per(), "R10 gap length", cyc - rise_cyc, per());
        gap_pending = 0;
      end
      if (!prev_cs && mem_cs_n) begin
        if (cfg_maxlow != 0)
          chk(cyc - fall_cyc <= int'(cfg_maxlow) * per(), "R9 low time", cyc - fall_cyc,
              int'(cfg_maxlow) * per());
        gap_pending = busy;
        rise_cyc = cyc;
      end
      if (done) done_cnt++;
      prev_cs = mem_cs_n;
    end
  end

  task automatic start_burst(input bit w, input logic [23:0] a, input logic [7:0] lm1);
    int pb = 0;
    int wpp = int'(cfg_maxlow) - int'(cfg_lat);
    logic [10:0] pm;
    case (cfg_page) 3'd1: pm = 127; 3'd2: pm = 255; 3'd3: pm = 511; 3'd4: pm = 1023; default: pm = 0; endcase
    rv_times.delete(); first_fall = -1;
    exp_piece.push_back(a);
    for (int i = 0; i <= int'(lm1); i++) begin
      logic [23:0] ai, nx;
      ai = a + 24'(2 * i); nx = ai + 24'd2;
      if (w) begin
        exp_wa.push_back(ai); exp_wd.push_back(16'hC000 ^ 16'(i * 37)); wdata_q.push_back(16'hC000 ^ 16'(i * 37));
      end else exp_rd.push_back(ai[15:0] ^ 16'h5A3C);
      pb++;
      if (i != int'(lm1) && ((pm != 0 && (nx[10:0] & pm) == 0) || (cfg_maxlow != 0 && pb == wpp))) begin
        exp_piece.push_back(nx); pb = 0;
      end
    end
    while (busy) @(negedge clk);
    req_write = w; req_addr = a; req_len_m1 = lm1; req_valid = 1;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic wait_done(input string tag);
    int d0 = done_cnt, n = 0;
    while (done_cnt == d0 && n < 20000) begin @(negedge clk); n++; end
    chk(done_cnt == d0 + 1, {tag, " done pulse"}, done_cnt - d0, 1);
    chk(!busy, {tag, " busy low at done"}, busy, 0);
    @(negedge clk);
    chk(!done, "R11 done is one cycle", done, 0);
    chk(exp_rd.size() == 0 && exp_wa.size() == 0, {tag, " all words seen"}, exp_rd.size() + exp_wa.size(), 0);
    chk(exp_piece.size() == 0, {tag, " all pieces seen"}, exp_piece.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int rises;
    bit pc;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && !mem_clk && !busy && !done && !rd_valid && !wr_ack, "R1 reset state",
        {mem_cs_n, mem_clk, busy, done, rd_valid, wr_ack}, 6'b100000);
    rst_n = 1;
    cfg_half = 2; repeat (2) @(negedge clk);
    // R2: idle clock gating
    rises = 0; pc = mem_clk;
    repeat (40) begin @(negedge clk); if (mem_clk && !pc) rises++; pc = mem_clk; end
    chk(rises == 0, "R2 clock stopped while idle", rises, 0);
    cfg_cclk = 1; @(negedge clk);
    rises = 0; pc = mem_clk;
    repeat (40) begin @(negedge clk); if (mem_clk && !pc) rises++; pc = mem_clk; end
    chk(rises == 10, "R2 continuous clock period", rises, 10);
    cfg_cclk = 0; cfg_half = 1; cfg_lat = 3;
    // R3 R4: plain read
    start_burst(0, 24'h000100, 8'd7);
    wait_done("R4 R11");
    chk(rv_times[0] - first_fall == 4 * per(), "R3 first word latency", rv_times[0] - first_fall, 4 * per());
    chk(rv_times[7] - rv_times[0] == 7 * per(), "R4 back-to-back words", rv_times[7] - rv_times[0], 7 * per());
    // R5: write
    cfg_lat = 2;
    start_burst(1, 24'h000040, 8'd4);
    wait_done("R5");
    // R8: page split at 128 bytes
    cfg_page = 3'd1;
    start_burst(0, 24'h00007A, 8'd5);
    wait_done("R8");
    // R9: low-time limit, 3 words per piece
    cfg_page = 3'd0; cfg_maxlow = 8'd5;
    start_burst(0, 24'h000200, 8'd6);
    wait_done("R9");
    start_burst(1, 24'h000300, 8'd3);
    wait_done("R9 write");
    cfg_maxlow = 8'd0;
    // R6: normal wait
    cfg_half = 2;
    start_burst(0, 24'h000400, 8'd3);
    while (!rd_valid) @(negedge clk);
    mem_wait = 1; repeat (per()) @(negedge clk); mem_wait = 0;
    wait_done("R6");
    chk(rv_times[1] - rv_times[0] == 2 * per(), "R6 stall in sampled cycle", rv_times[1] - rv_times[0], 2 * per());
    chk(rv_times[2] - rv_times[1] == per(), "R6 no further stall", rv_times[2] - rv_times[1], per());
    // R7: early wait
    cfg_wait_early = 1;
    start_burst(0, 24'h000500, 8'd3);
    while (!rd_valid) @(negedge clk);
    mem_wait = 1; repeat (per()) @(negedge clk); mem_wait = 0;
    wait_done("R7");
    chk(rv_times[1] - rv_times[0] == per(), "R7 sampled cycle not stalled", rv_times[1] - rv_times[0], per());
    chk(rv_times[2] - rv_times[1] == 2 * per(), "R7 following cycle stalled", rv_times[2] - rv_times[1], 2 * per());
    // R3: wait ignored during latency
    mem_wait = 1;
    start_burst(0, 24'h000600, 8'd2);
    while (!rd_valid) @(negedge clk);
    mem_wait = 0;
    wait_done("R3 R7");
    chk(rv_times[0] - first_fall == 3 * per(), "R3 latency ignores wait", rv_times[0] - first_fall, 3 * per());
    chk(rv_times[1] - rv_times[0] == 2 * per(), "R7 wait after latency", rv_times[1] - rv_times[0], 2 * per());
    cfg_wait_early = 0; cfg_half = 1;
    // R12 R8: full 256-word burst across a 1024-byte page
    cfg_page = 3'd4;
    start_burst(0, 24'h0003F0, 8'd255);
    wait_done("R12 R8");
    chk(rv_times.size() == 256, "R12 word count", rv_times.size(), 256);
    cfg_page = 3'd0;
    // R12: request while busy ignored
    start_burst(0, 24'h000700, 8'd2);
    repeat (2) @(negedge clk);
    req_write = 1; req_addr = 24'h000800; req_len_m1 = 8'd1; req_valid = 1;
    @(negedge clk); req_valid = 0;
    wait_done("R12 ignore");
    repeat (30) @(negedge clk);
    chk(mem_cs_n && !busy, "R12 busy request left no burst", {mem_cs_n, busy}, 2'b10);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule